// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two single-bit guesses for each branch and a third single-bit table that picks between them. The first guess is what the branch did the last time it resolved. The second comes from a table whose index mixes the branch address with a shift register of recent outcomes. The selector bit for each branch records which of the two guesses has lately been right.

A fetch stage drives the lookup address and reads the final guess in the same cycle, along with both component guesses. It holds the two component guesses alongside the branch. When the branch resolves, the back end returns the address, the real outcome and those two stored guesses. The block then writes the real outcome into both component tables and into the history register. It moves the selector bit only when the two stored guesses differed.

Table depth and history length are parameters. The default is 2^11 entries per table with 11 history bits, and the design also scales to 2^14 entries.

Top module: `tournament_bp`

## Requirements
- R1: After reset, every table bit, every selector bit and the history register are zero, so every lookup gives 0 on all three prediction outputs.
- R2: On a resolve, the last-outcome table entry of that branch is overwritten with the real outcome. A later lookup of the same branch shows that outcome on `lk_local_pred`.
- R3: The last-outcome table and the selector table are both indexed by address bits [IDX_W+1:2]. Addresses that differ only outside those bits share entries.
- R4: The history table is read with index addr[IDX_W+1:2] XOR the history, zero-extended to IDX_W bits. On a resolve it is written at the index formed from the resolve address and the history held before that resolve.
- R5: Each resolve shifts the history left by one. The real outcome enters bit 0 and the oldest bit is dropped.
- R6: The selector bit of a branch is written only on a resolve where the two supplied component guesses differ. It is set to 1 when the history-table guess matched the outcome and to 0 when the last-outcome guess matched.
- R7: `lk_taken` equals `lk_global_pred` when the branch's selector bit is 1 and `lk_local_pred` when it is 0. It is produced combinationally in the lookup cycle.
- R8: A lookup in the same cycle as a resolve sees the table and history contents from before that resolve.
- R9: The selector update uses the component guesses supplied on the resolve port, not the current table contents.
- R10: With `rs_valid` low, no table bit and no history bit changes, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Final taken guess |
| lk_local_pred | output | 1 | Guess from the last-outcome table |
| lk_global_pred | output | 1 | Guess from the history table |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Real outcome |
| rs_local_pred | input | 1 | Last-outcome guess stored at lookup |
| rs_global_pred | input | 1 | History-table guess stored at lookup |

## Verification
Fixed runs first separate the two component tables. They resolve one branch and read it back under aliased and non-aliased addresses, then feed a short outcome sequence so the history-table guess moves while the last-outcome guess stays put. Resolves with disagreeing, agreeing and deliberately stale component guesses show whether the selector reacts only to disagreement and trusts the supplied guesses. A lookup of the branch being resolved in the same cycle, and idle cycles with junk on the resolve inputs, test update timing and the enable. A long random mix over a small set of addresses then makes aliasing and history-driven indexing interact, and it is compared with the behavioural model every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {SRC_LOCAL = 1'b0, SRC_GLOBAL = 1'b1} bp_src_e;

  function automatic logic pick_pred(input bp_src_e src, input logic loc, input logic glb);
    return (src == SRC_GLOBAL) ? glb : loc;
  endfunction

  function automatic bp_src_e winner(input logic glb_guess, input logic outcome);
    return (glb_guess == outcome) ? SRC_GLOBAL : SRC_LOCAL;
  endfunction
endpackage

// File: rtl/bp_bit_table.sv
module bp_bit_table #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else if (wr_en) bits_q[wr_idx] <= wr_bit;
  end

  assign rd_bit = bits_q[rd_idx];
endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              in_bit,
  output logic [HIST_W-1:0] hist,
  output logic [HIST_W-1:0] hist_next
);
  function automatic logic [HIST_W-1:0] shift_in(input logic [HIST_W-1:0] h, input logic b);
    return {h[HIST_W-2:0], b};
  endfunction

  assign hist_next = shift_in(hist, in_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else if (shift_en) hist <= hist_next;
  end
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 11,
  parameter int HIST_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_local_pred,
  output logic            lk_global_pred,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic            rs_local_pred,
  input  logic            rs_global_pred
);
  import bp_pkg::*;

  typedef logic [IDX_W-1:0] idx_t;

  function automatic idx_t site_idx(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  function automatic idx_t mixed_idx(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
    idx_t ext;
    ext = '0;
    ext[HIST_W-1:0] = h;
    return pc[IDX_W+1:2] ^ ext;
  endfunction

  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] hist_next;
  idx_t    lk_site, lk_mix, rs_site, rs_mix;
  logic    lk_choice_bit;
  bp_src_e lk_choice;
  logic    chooser_wr_en;
  bp_src_e chooser_wr_src;
  logic    chooser_wr_bit;
  logic    unused_pc_bits;

  assign lk_site = site_idx(lk_pc);
  assign lk_mix  = mixed_idx(lk_pc, hist);
  assign rs_site = site_idx(rs_pc);
  assign rs_mix  = mixed_idx(rs_pc, hist);

  assign chooser_wr_en  = rs_valid && (rs_local_pred != rs_global_pred);
  assign chooser_wr_src = winner(rs_global_pred, rs_taken);
  assign chooser_wr_bit = chooser_wr_src;

  bp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(rs_valid), .in_bit(rs_taken),
    .hist(hist), .hist_next(hist_next)
  );

  bp_bit_table #(.IDX_W(IDX_W)) u_local (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_site), .rd_bit(lk_local_pred),
    .wr_en(rs_valid), .wr_idx(rs_site), .wr_bit(rs_taken)
  );

  bp_bit_table #(.IDX_W(IDX_W)) u_global (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_mix), .rd_bit(lk_global_pred),
    .wr_en(rs_valid), .wr_idx(rs_mix), .wr_bit(rs_taken)
  );

  bp_bit_table #(.IDX_W(IDX_W)) u_chooser (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_site), .rd_bit(lk_choice_bit),
    .wr_en(chooser_wr_en), .wr_idx(rs_site), .wr_bit(chooser_wr_bit)
  );

  assign lk_choice = bp_src_e'(lk_choice_bit);
  assign lk_taken  = pick_pred(lk_choice, lk_local_pred, lk_global_pred);

  assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_W+2], lk_pc[1:0],
                            rs_pc[PC_W-1:IDX_W+2], rs_pc[1:0], hist_next};
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int HIST_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_taken,
  input logic              lk_local_pred,
  input logic              lk_global_pred,
  input logic              lk_choice_bit,
  input logic              rs_valid,
  input logic              rs_taken,
  input logic              rs_local_pred,
  input logic              rs_global_pred,
  input logic              chooser_wr_en,
  input logic              chooser_wr_bit,
  input logic [HIST_W-1:0] hist
);
  // R5: the outcome lands in bit 0 and the rest move up one place
  p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> (hist == {$past(hist[HIST_W-2:0]), $past(rs_taken)}));

  // R10: no resolve, no history movement
  p_hist_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(hist));

  // R6: agreeing guesses leave the selector alone
  p_chooser_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && (rs_local_pred == rs_global_pred)) |-> !chooser_wr_en);

  // R6: a selector write points at the component that was right
  p_chooser_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chooser_wr_en |-> ((chooser_wr_bit == 1'b1) == (rs_global_pred == rs_taken)));

  // R7: a final guess unlike the last-outcome guess must come from the history table
  p_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_taken != lk_local_pred) |-> (lk_choice_bit && (lk_taken == lk_global_pred)));
endmodule

bind tournament_bp bp_checker #(.HIST_W(HIST_W)) u_bp_checker (
  .clk(clk), .rst_n(rst_n),
  .lk_taken(lk_taken), .lk_local_pred(lk_local_pred), .lk_global_pred(lk_global_pred),
  .lk_choice_bit(lk_choice_bit),
  .rs_valid(rs_valid), .rs_taken(rs_taken),
  .rs_local_pred(rs_local_pred), .rs_global_pred(rs_global_pred),
  .chooser_wr_en(chooser_wr_en), .chooser_wr_bit(chooser_wr_bit),
  .hist(hist)
);

// File: tb/test_tournament_bp.sv
`timescale 1ns/1ps
module test_tournament_bp;
  localparam int IDX_W  = 11;
  localparam int HIST_W = 11;
  localparam int N      = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic lk_taken, lk_local_pred, lk_global_pred;
  logic rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic rs_taken = 1'b0, rs_local_pred = 1'b0, rs_global_pred = 1'b0;

  always #2.5 clk = ~clk;

  tournament_bp #(.PC_W(32), .IDX_W(IDX_W), .HIST_W(HIST_W)) i_tournament_bp (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_local_pred(lk_local_pred), .lk_global_pred(lk_global_pred),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_local_pred(rs_local_pred), .rs_global_pred(rs_global_pred)
  );

  // behavioural reference
  bit m_last[N];
  bit m_hpat[N];
  bit m_sel[N];
  int unsigned m_hist;
  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input string tag, input string what, input logic act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input int unsigned lpc, input bit rv, input int unsigned rpc,
                      input bit rt, input bit rl, input bit rg, input string tag);
    int unsigned li, gi;
    bit el, eg, et;
    @(negedge clk);
    lk_pc = lpc; rs_valid = rv; rs_pc = rpc;
    rs_taken = rt; rs_local_pred = rl; rs_global_pred = rg;
    #1;
    li = (lpc >> 2) % N;
    gi = ((lpc >> 2) ^ m_hist) % N;
    el = m_last[li];
    eg = m_hpat[gi];
    et = m_sel[li] ? eg : el;
    check(tag, "local", lk_local_pred, el);
    check(tag, "global", lk_global_pred, eg);
    check(tag, "final", lk_taken, et);
    @(posedge clk);
    if (rv) begin
      li = (rpc >> 2) % N;
      gi = ((rpc >> 2) ^ m_hist) % N;
      m_last[li] = rt;
      m_hpat[gi] = rt;
      if (rl != rg) m_sel[li] = (rg == rt);
      m_hist = ((m_hist << 1) | rt) % (1 << HIST_W);
    end
  endtask

  task automatic look(input int unsigned lpc, input string tag);
    step(lpc, 0, 32'h0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    m_hist = 0;
    for (int i = 0; i < N; i++) begin m_last[i] = 0; m_hpat[i] = 0; m_sel[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything cleared
    look(32'h0000_0100, "R1");
    look(32'h0000_abc4, "R1");
    look(32'hffff_fffc, "R1");

    // R2: last-outcome table takes the real outcome
    step(32'h0, 1, 32'h0000_0040, 1, 0, 0, "R2");
    look(32'h0000_0040, "R2");

    // R3: aliasing outside the index bits, neighbour unaffected
    look(32'h0000_0040 + (32'h1 << (IDX_W + 2)), "R3");
    look(32'h0000_0043, "R3");
    look(32'h0000_0044, "R3");

    // R4/R5: outcome pattern drives history-based index
    step(32'h0, 1, 32'h0000_0200, 1, 0, 0, "R5");
    step(32'h0, 1, 32'h0000_0200, 0, 0, 0, "R5");
    step(32'h0, 1, 32'h0000_0200, 1, 0, 0, "R5");
    step(32'h0, 1, 32'h0000_0200, 1, 0, 0, "R5");
    for (int k = 0; k < 8; k++) look(32'h0000_0200 + 4 * k, "R4");

    // R6: disagreement with global right, agreement, then local right
    step(32'h0, 1, 32'h0000_0300, 1, 0, 1, "R6");
    look(32'h0000_0300, "R6");
    step(32'h0, 1, 32'h0000_0300, 0, 0, 0, "R6");
    look(32'h0000_0300, "R6");
    step(32'h0, 1, 32'h0000_0300, 1, 1, 0, "R6");
    look(32'h0000_0300, "R6");

    // R8: same-cycle lookup sees old state
    step(32'h0000_0500, 1, 32'h0000_0500, 1, 0, 1, "R8");
    look(32'h0000_0500, "R8");

    // R9: stale guesses supplied on resolve drive the selector
    step(32'h0, 1, 32'h0000_0600, 0, 0, 1, "R9");
    step(32'h0, 1, 32'h0000_0600, 0, 1, 0, "R9");
    look(32'h0000_0600, "R9");
    step(32'h0, 1, 32'h0000_0600, 1, 0, 1, "R9");
    look(32'h0000_0600, "R9");

    // R10: junk on resolve inputs without valid
    step(32'h0000_0040, 0, 32'h0000_0040, 0, 1, 0, "R10");
    step(32'h0000_0300, 0, 32'h0000_0300, 0, 0, 1, "R10");
    look(32'h0000_0040, "R10");
    look(32'h0000_0300, "R10");

    // R7: random mix over a small address set
    for (int k = 0; k < 800; k++) begin
      step($urandom_range(0, 31) * 4, 1'($urandom_range(0, 1)),
           $urandom_range(0, 31) * 4, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R7");
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule